// File: doc/BRIEF.md
# Calendar Timekeeping Counter Chain

This block keeps the time of day and the calendar date from a 100 Hz tick enable. A chain of BCD counters holds hundredths of a second, seconds, minutes, hours, day of the week, date of the month, month and a two-digit year. Each tick moves the hundredths count forward. When a count wraps, the carry passes through every higher field in the same clock cycle. The date wraps at the real last day of each month. February has 29 days whenever the year value is a multiple of four.

A mode input selects whether hours are counted on a 24-hour or a 12-hour dial. On the 12-hour dial an AM/PM flag is kept beside the hour. Software sets every field at once with a single load strobe. It reads the fields through a snapshot bank: a snapshot strobe copies all live fields in one edge, so no carry can change a field part-way through a read.

Top module: `cal_chain_top`

## Requirements
- R1: After a synchronous reset, the live and snapshot fields are 00.00 hundredths/seconds, 00 minutes, hour 00, PM flag 0, weekday 1, date 01, month 01 and year 00.
- R2: All fields are BCD, with the high digit in bits 7:4. Hundredths advance by one only in a cycle where tick is 1 and load is 0, so with tick at 0 nothing changes. Hundredths wrap from 99 to 00 and carry into seconds.
- R3: Seconds and minutes each wrap from 59 to 00 and pass a carry to the next field in the same cycle.
- R4: With mode12 at 0, hours run from 00 to 23. The step from 23 to 00 moves the calendar forward by one day.
- R5: With mode12 at 1, hours run 12, 01, ..., 11. The PM flag (1 means PM) toggles on the step from 11 to 12. The step from 11 PM to 12 AM moves the calendar forward by one day.
- R6: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months apart from February.
- R7: February ends after day 29 when the year value is divisible by 4, year 00 included, and after day 28 in all other years.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: The weekday field, 3 bits wide, advances with each day carry and wraps from 7 to 1.
- R10: When load is 1, every field and the PM flag take the load inputs at the next edge. Load takes priority over a tick in the same cycle.
- R11: When snap is 1, the read outputs take the live values held just before that edge. When snap is 0, the read outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| mode12 | input | 1 | 1 selects 12-hour counting, 0 selects 24-hour counting |
| load | input | 1 | Writes all load inputs into the live fields |
| ld_hund | input | 8 | BCD hundredths to load |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hour to load |
| ld_pm | input | 1 | PM flag to load |
| ld_dow | input | 3 | Weekday to load (1..7) |
| ld_date | input | 8 | BCD date to load |
| ld_mon | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| snap | input | 1 | Copies the live fields into the read bank |
| rd_hund | output | 8 | Snapshot hundredths |
| rd_sec | output | 8 | Snapshot seconds |
| rd_min | output | 8 | Snapshot minutes |
| rd_hour | output | 8 | Snapshot hour |
| rd_pm | output | 1 | Snapshot PM flag |
| rd_dow | output | 3 | Snapshot weekday |
| rd_date | output | 8 | Snapshot date |
| rd_mon | output | 8 | Snapshot month |
| rd_year | output | 8 | Snapshot year |

## Verification
The range properties assume that every load writes a legal, self-consistent set of values: BCD digits only, a date that exists in the loaded month and year, and an hour that suits the mode selected in that same cycle. The bench changes mode12 only in a cycle where it also loads a matching hour, and it loads only real calendar dates. Ticks arrive either in every cycle or in a pseudo-random pattern. Starting points are loaded just before each rollover so that every carry path is reached within a few ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DOW_W = 3;

    typedef struct packed {
        logic [7:0]       hund;
        logic [7:0]       sec;
        logic [7:0]       min;
        logic [7:0]       hour;
        logic             pm;
        logic [DOW_W-1:0] dow;
        logic [7:0]       date;
        logic [7:0]       mon;
        logic [7:0]       year;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = '{
        hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00, pm: 1'b0,
        dow: DOW_W'(1), date: 8'h01, mon: 8'h01, year: 8'h00
    };

    // one BCD step, digits assumed legal
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // (10*t + u) mod 4 == 0  <=>  (2*t + u) mod 4 == 0
    function automatic logic is_leap(input logic [7:0] yr);
        if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
    parameter logic [7:0] FIRST   = 8'h00,
    parameter logic [7:0] LAST    = 8'h59,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       ld,
    input  logic [7:0] ld_val,
    output logic [7:0] q,
    output logic       carry
);
    assign carry = adv && (q == LAST);

    always_ff @(posedge clk) begin
        if (rst)      q <= RST_VAL;
        else if (ld)  q <= ld_val;
        else if (adv) q <= carry ? FIRST : rtc_pkg::bcd_inc(q);
    end
endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       ld,
    input  logic       mode12,
    input  logic [7:0] ld_hund,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic       ld_pm,
    output logic [7:0] hund,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic       pm,
    output logic       day_carry
);
    localparam int unsigned NSTAGE = 3;
    localparam logic [7:0] STAGE_LAST [NSTAGE] = '{8'h99, 8'h59, 8'h59};

    logic [7:0]      cnt  [NSTAGE];
    logic [7:0]      ldv  [NSTAGE];
    logic [NSTAGE:0] adv;

    assign ldv[0] = ld_hund;
    assign ldv[1] = ld_sec;
    assign ldv[2] = ld_min;
    assign adv[0] = tick_en;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        rtc_bcd_wrap #(
            .FIRST(8'h00), .LAST(STAGE_LAST[g]), .RST_VAL(8'h00)
        ) u_cnt (
            .clk(clk), .rst(rst), .adv(adv[g]), .ld(ld),
            .ld_val(ldv[g]), .q(cnt[g]), .carry(adv[g+1])
        );
    end

    assign hund = cnt[0];
    assign sec  = cnt[1];
    assign min  = cnt[2];

    logic [7:0] hour_nxt;
    logic       pm_nxt;
    logic       wrap_day;

    always_comb begin
        hour_nxt = rtc_pkg::bcd_inc(hour);
        pm_nxt   = pm;
        wrap_day = 1'b0;
        if (mode12) begin
            if (hour == 8'h11) begin
                hour_nxt = 8'h12;
                pm_nxt   = ~pm;
                wrap_day = pm;
            end else if (hour == 8'h12) begin
                hour_nxt = 8'h01;
            end
        end else if (hour == 8'h23) begin
            hour_nxt = 8'h00;
            wrap_day = 1'b1;
        end
    end

    assign day_carry = adv[NSTAGE] && wrap_day;

    always_ff @(posedge clk) begin
        if (rst) begin
            hour <= rtc_pkg::RTC_RESET.hour;
            pm   <= rtc_pkg::RTC_RESET.pm;
        end else if (ld) begin
            hour <= ld_hour;
            pm   <= ld_pm;
        end else if (adv[NSTAGE]) begin
            hour <= hour_nxt;
            pm   <= pm_nxt;
        end
    end
endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain #(
    parameter int unsigned DOW_DAYS = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      day_adv,
    input  logic                      ld,
    input  logic [rtc_pkg::DOW_W-1:0] ld_dow,
    input  logic [7:0]                ld_date,
    input  logic [7:0]                ld_mon,
    input  logic [7:0]                ld_year,
    output logic [rtc_pkg::DOW_W-1:0] dow,
    output logic [7:0]                date,
    output logic [7:0]                mon,
    output logic [7:0]                year
);
    localparam int unsigned DW = rtc_pkg::DOW_W;
    localparam logic [DW-1:0] DOW_END = DW'(DOW_DAYS);

    logic date_end, mon_adv, year_adv;

    assign date_end = (date == rtc_pkg::month_last(mon, year));
    assign mon_adv  = day_adv && date_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            dow  <= rtc_pkg::RTC_RESET.dow;
            date <= rtc_pkg::RTC_RESET.date;
            year <= rtc_pkg::RTC_RESET.year;
        end else if (ld) begin
            dow  <= ld_dow;
            date <= ld_date;
            year <= ld_year;
        end else begin
            if (day_adv) begin
                dow  <= (dow == DOW_END) ? DW'(1) : dow + DW'(1);
                date <= date_end ? 8'h01 : rtc_pkg::bcd_inc(date);
            end
            if (year_adv)
                year <= (year == 8'h99) ? 8'h00 : rtc_pkg::bcd_inc(year);
        end
    end

    rtc_bcd_wrap #(
        .FIRST(8'h01), .LAST(8'h12), .RST_VAL(8'h01)
    ) u_month (
        .clk(clk), .rst(rst), .adv(mon_adv), .ld(ld),
        .ld_val(ld_mon), .q(mon), .carry(year_adv)
    );
endmodule

// File: rtl/rtc_snap_reg.sv
module rtc_snap_reg #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= RST_VAL;
        else if (cap) q <= d;
    end
endmodule

// File: rtl/cal_chain_top.sv
module cal_chain_top #(
    parameter int unsigned DOW_DAYS = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      mode12,
    input  logic                      load,
    input  logic [7:0]                ld_hund,
    input  logic [7:0]                ld_sec,
    input  logic [7:0]                ld_min,
    input  logic [7:0]                ld_hour,
    input  logic                      ld_pm,
    input  logic [rtc_pkg::DOW_W-1:0] ld_dow,
    input  logic [7:0]                ld_date,
    input  logic [7:0]                ld_mon,
    input  logic [7:0]                ld_year,
    input  logic                      snap,
    output logic [7:0]                rd_hund,
    output logic [7:0]                rd_sec,
    output logic [7:0]                rd_min,
    output logic [7:0]                rd_hour,
    output logic                      rd_pm,
    output logic [rtc_pkg::DOW_W-1:0] rd_dow,
    output logic [7:0]                rd_date,
    output logic [7:0]                rd_mon,
    output logic [7:0]                rd_year
);
    import rtc_pkg::*;

    localparam int unsigned TW = $bits(rtc_time_t);

    rtc_time_t live, ld_v, rd_v;
    logic      tick_en, day_carry;

    assign tick_en = tick && !load;

    assign ld_v = '{hund: ld_hund, sec: ld_sec, min: ld_min, hour: ld_hour,
                    pm: ld_pm, dow: ld_dow, date: ld_date, mon: ld_mon,
                    year: ld_year};

    rtc_clock_chain u_clock (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ld(load), .mode12(mode12),
        .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min),
        .ld_hour(ld_hour), .ld_pm(ld_pm),
        .hund(live.hund), .sec(live.sec), .min(live.min),
        .hour(live.hour), .pm(live.pm), .day_carry(day_carry)
    );

    rtc_calendar_chain #(.DOW_DAYS(DOW_DAYS)) u_cal (
        .clk(clk), .rst(rst), .day_adv(day_carry), .ld(load),
        .ld_dow(ld_dow), .ld_date(ld_date), .ld_mon(ld_mon), .ld_year(ld_year),
        .dow(live.dow), .date(live.date), .mon(live.mon), .year(live.year)
    );

    rtc_snap_reg #(.W(TW), .RST_VAL(TW'(RTC_RESET))) u_snap (
        .clk(clk), .rst(rst), .cap(snap), .d(live), .q(rd_v)
    );

    assign rd_hund = rd_v.hund;
    assign rd_sec  = rd_v.sec;
    assign rd_min  = rd_v.min;
    assign rd_hour = rd_v.hour;
    assign rd_pm   = rd_v.pm;
    assign rd_dow  = rd_v.dow;
    assign rd_date = rd_v.date;
    assign rd_mon  = rd_v.mon;
    assign rd_year = rd_v.year;
endmodule

// File: rtl/cal_chain_chk.sv
module cal_chain_chk (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               load,
    input logic               snap,
    input logic               mode12,
    input rtc_pkg::rtc_time_t live,
    input rtc_pkg::rtc_time_t ld_v,
    input rtc_pkg::rtc_time_t rd
);
    logic adv, hour_step;
    assign adv       = tick && !load;
    assign hour_step = adv && live.hund == 8'h99 && live.sec == 8'h59 && live.min == 8'h59;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> live == $past(live));

    p_hund_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && live.hund == 8'h99) |=> (live.hund == 8'h00 && live.sec != $past(live.sec)));

    p_min_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        hour_step |=> (live.min == 8'h00 && live.sec == 8'h00));

    p_day_24_r4: assert property (@(posedge clk) disable iff (rst)
        (hour_step && !mode12 && live.hour == 8'h23) |=>
            (live.hour == 8'h00 && live.date != $past(live.date)));

    p_pm_flip_r5: assert property (@(posedge clk) disable iff (rst)
        (hour_step && mode12 && live.hour == 8'h11) |=>
            (live.hour == 8'h12 && live.pm != $past(live.pm)));

    p_date_range_r6: assert property (@(posedge clk) disable iff (rst)
        live.date >= 8'h01 && live.date <= rtc_pkg::month_last(live.mon, live.year));

    p_dow_range_r9: assert property (@(posedge clk) disable iff (rst)
        live.dow >= 3'd1 && live.dow <= 3'd7);

    p_load_all_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> live == $past(ld_v));

    p_snap_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(rd));

    p_snap_take_r11: assert property (@(posedge clk) disable iff (rst)
        snap |=> rd == $past(live));
endmodule

bind cal_chain_top cal_chain_chk i_chk (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .snap(snap),
    .mode12(mode12), .live(live), .ld_v(ld_v), .rd(rd_v)
);

// File: tb/test_cal_chain_top.sv
module test_cal_chain_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, mode12 = 1'b0, load = 1'b0, snap = 1'b1;
    logic [7:0] ld_hund = '0, ld_sec = '0, ld_min = '0, ld_hour = '0;
    logic       ld_pm = 1'b0;
    logic [2:0] ld_dow = 3'd1;
    logic [7:0] ld_date = 8'h01, ld_mon = 8'h01, ld_year = '0;
    logic [7:0] rd_hund, rd_sec, rd_min, rd_hour, rd_date, rd_mon, rd_year;
    logic       rd_pm;
    logic [2:0] rd_dow;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    lfsr = 32'h1ace;

    always #4 clk = ~clk;

    cal_chain_top i_cal_chain_top (
        .clk(clk), .rst(rst), .tick(tick), .mode12(mode12), .load(load),
        .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_pm(ld_pm), .ld_dow(ld_dow), .ld_date(ld_date), .ld_mon(ld_mon),
        .ld_year(ld_year), .snap(snap),
        .rd_hund(rd_hund), .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour),
        .rd_pm(rd_pm), .rd_dow(rd_dow), .rd_date(rd_date), .rd_mon(rd_mon),
        .rd_year(rd_year)
    );

    // behavioural reference: plain integers, index 0..8 =
    // hund sec min hour pm dow date mon year
    int m_cur [9];
    int m_rd  [9];

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_cur = '{0, 0, 0, 0, 0, 1, 1, 1, 0};
        m_rd  = m_cur;
    endtask

    task automatic model_day();
        m_cur[5] = (m_cur[5] == 7) ? 1 : m_cur[5] + 1;
        if (m_cur[6] == days_in(m_cur[7], m_cur[8])) begin
            m_cur[6] = 1;
            m_cur[7] = m_cur[7] + 1;
            if (m_cur[7] == 13) begin
                m_cur[7] = 1;
                m_cur[8] = (m_cur[8] + 1) % 100;
            end
        end else m_cur[6] = m_cur[6] + 1;
    endtask

    task automatic model_hour(input bit h12);
        if (!h12) begin
            m_cur[3] = m_cur[3] + 1;
            if (m_cur[3] == 24) begin m_cur[3] = 0; model_day(); end
        end else if (m_cur[3] == 11) begin
            m_cur[3] = 12;
            m_cur[4] = 1 - m_cur[4];
            if (m_cur[4] == 0) model_day();
        end else if (m_cur[3] == 12) m_cur[3] = 1;
        else m_cur[3] = m_cur[3] + 1;
    endtask

    task automatic model_tick(input bit h12);
        m_cur[0] = m_cur[0] + 1;
        if (m_cur[0] < 100) return;
        m_cur[0] = 0;
        m_cur[1] = m_cur[1] + 1;
        if (m_cur[1] < 60) return;
        m_cur[1] = 0;
        m_cur[2] = m_cur[2] + 1;
        if (m_cur[2] < 60) return;
        m_cur[2] = 0;
        model_hour(h12);
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            if (snap) m_rd = m_cur;
            if (load)
                m_cur = '{b2i(ld_hund), b2i(ld_sec), b2i(ld_min), b2i(ld_hour),
                          int'(ld_pm), int'(ld_dow), b2i(ld_date), b2i(ld_mon),
                          b2i(ld_year)};
            else if (tick) model_tick(mode12);
        end
    end

    // compare the whole read bank against the model on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [59:0] act, exp;
            act = {rd_hund, rd_sec, rd_min, rd_hour, rd_pm, rd_dow, rd_date, rd_mon, rd_year};
            exp = {i2b(m_rd[0]), i2b(m_rd[1]), i2b(m_rd[2]), i2b(m_rd[3]),
                   1'(m_rd[4]), 3'(m_rd[5]), i2b(m_rd[6]), i2b(m_rd[7]), i2b(m_rd[8])};
            n_chk++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s cycle compare act=%h exp=%h", cur_req, act, exp);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode 0: tick every cycle, mode 1: pseudo-random ticks
    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            load = 1'b0;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
            tick = (mode == 0) ? 1'b1 : lfsr[0];
        end
    endtask

    task automatic settle();
        @(posedge clk); #2;
        load = 1'b0; tick = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_all(input bit m12, input logic [7:0] hr, input bit pmv,
                           input logic [7:0] mi, input logic [7:0] se, input logic [7:0] hu,
                           input logic [2:0] dw, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr, input bit tk);
        @(posedge clk); #2;
        load = 1'b1; tick = tk; mode12 = m12;
        ld_hour = hr; ld_pm = pmv; ld_min = mi; ld_sec = se; ld_hund = hu;
        ld_dow = dw; ld_date = dt; ld_mon = mo; ld_year = yr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 hour", rd_hour, 8'h00);
        chk("R1 date", rd_date, 8'h01);
        chk("R1 dow", {5'd0, rd_dow}, 8'h01);
        chk("R1 mon", rd_mon, 8'h01);

        cur_req = "R2";
        run(400, 1);
        run(50, 0);
        settle();
        chk("R2 hund frozen without tick", rd_hund, i2b(m_cur[0]));

        cur_req = "R3";
        set_all(0, 8'h00, 0, 8'h58, 8'h59, 8'h90, 3'd2, 8'h10, 8'h03, 8'h21, 0);
        run(20, 0); settle();
        chk("R3 min carried", rd_min, 8'h59);
        chk("R3 sec wrapped", rd_sec, 8'h00);

        cur_req = "R4";
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h95, 3'd3, 8'h14, 8'h06, 8'h21, 0);
        run(10, 0); settle();
        chk("R4 hour wrap", rd_hour, 8'h00);
        chk("R4 day carry", rd_date, 8'h15);

        cur_req = "R5";
        set_all(1, 8'h11, 0, 8'h59, 8'h59, 8'h97, 3'd2, 8'h05, 8'h07, 8'h22, 0);
        run(8, 0); settle();
        chk("R5 noon hour", rd_hour, 8'h12);
        chk("R5 pm set", {7'd0, rd_pm}, 8'h01);
        chk("R5 no day at noon", rd_date, 8'h05);
        set_all(1, 8'h12, 1, 8'h59, 8'h59, 8'h98, 3'd2, 8'h05, 8'h07, 8'h22, 0);
        run(8, 1); run(8, 0); settle();
        chk("R5 12 to 01", rd_hour, 8'h01);
        set_all(1, 8'h11, 1, 8'h59, 8'h59, 8'h98, 3'd2, 8'h05, 8'h07, 8'h22, 0);
        run(8, 0); settle();
        chk("R5 midnight hour", rd_hour, 8'h12);
        chk("R5 am", {7'd0, rd_pm}, 8'h00);
        chk("R5 midnight date", rd_date, 8'h06);

        cur_req = "R6";
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd4, 8'h30, 8'h04, 8'h22, 0);
        run(6, 0); settle();
        chk("R6 april end date", rd_date, 8'h01);
        chk("R6 april end mon", rd_mon, 8'h05);
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd4, 8'h30, 8'h11, 8'h22, 0);
        run(6, 0); settle();
        chk("R6 november end", rd_mon, 8'h12);
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd4, 8'h30, 8'h01, 8'h22, 0);
        run(6, 0); settle();
        chk("R6 january 31st", rd_date, 8'h31);

        cur_req = "R7";
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd1, 8'h28, 8'h02, 8'h23, 0);
        run(6, 0); settle();
        chk("R7 common feb", rd_mon, 8'h03);
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd1, 8'h28, 8'h02, 8'h24, 0);
        run(6, 0); settle();
        chk("R7 leap 29th", rd_date, 8'h29);
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd1, 8'h29, 8'h02, 8'h24, 0);
        run(6, 0); settle();
        chk("R7 leap end", rd_mon, 8'h03);
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd1, 8'h28, 8'h02, 8'h00, 0);
        run(6, 0); settle();
        chk("R7 year 00 leap", rd_date, 8'h29);
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd1, 8'h28, 8'h02, 8'h18, 0);
        run(6, 0); settle();
        chk("R7 year 18 common", rd_date, 8'h01);

        cur_req = "R8";
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h98, 3'd7, 8'h31, 8'h12, 8'h99, 0);
        run(6, 0); settle();
        chk("R8 year wrap", rd_year, 8'h00);
        chk("R8 month wrap", rd_mon, 8'h01);
        chk("R9 dow wrap", {5'd0, rd_dow}, 8'h01);

        cur_req = "R9";
        set_all(0, 8'h23, 0, 8'h59, 8'h59, 8'h99, 3'd6, 8'h12, 8'h08, 8'h30, 0);
        run(3, 0); settle();
        chk("R9 dow step", {5'd0, rd_dow}, 8'h07);

        cur_req = "R10";
        set_all(0, 8'h07, 0, 8'h15, 8'h30, 8'h45, 3'd5, 8'h20, 8'h10, 8'h45, 1);
        settle();
        chk("R10 hund over tick", rd_hund, 8'h45);
        chk("R10 year", rd_year, 8'h45);
        chk("R10 min", rd_min, 8'h15);

        cur_req = "R11";
        begin
            logic [7:0] held;
            @(posedge clk); #2 snap = 1'b0;
            @(negedge clk);
            held = rd_hund;
            run(40, 0);
            @(negedge clk);
            chk("R11 hold while snap low", rd_hund, held);
            @(posedge clk); #2 snap = 1'b1;
            run(10, 1);
            settle();
            chk("R11 snapshot refresh", rd_hund, i2b(m_cur[0]));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule